// File: doc/BRIEF.md
# Four-Channel Serial Converter Port Model

This block is a synthesizable model of the device side of the serial port on a four-channel, 10-bit successive-approximation converter. The host drives an active-low select, a serial clock and a serial data line. The block returns the conversion result on a serial output that is enabled only while select is low. Four parallel 10-bit ports stand in for the analog inputs. The block latches the chosen port at the hold instant and shifts out a 16-bit word, most significant bit first.

The block runs on its own system clock. It synchronizes the three serial pins and detects their edges. Each conversion lasts 16 serial clocks, and conversions follow one another while select stays low. The channel address carried by the control word of one conversion selects the input for the conversion after it. Two status flags report the tracking window and the power-down window. The output enable is a separate port, and the pad ring builds the tri-state driver from it.

Top module: `serial_adc_port`

## Requirements
- R1: `sdoOe` is 0 while `csN` is high and 1 while a frame is open (`csN` low). After reset, `sdoOe` is 0.
- R2: `sdoBit` changes only in response to a falling serial clock edge inside a frame. `sdi` is taken on rising serial clock edges.
- R3: The control word is 8 bits, sent MSB first on rising edges 1 to 8 of a conversion. Bits 4:3 give the channel: 00 selects port 0 (`chanData[9:0]`), 01 port 1, 10 port 2, 11 port 3. All other bits of the word have no effect.
- R4: The address received during a conversion selects the input of the next conversion, even when that conversion is in a later frame.
- R5: The first conversion after reset uses port 0.
- R6: The output word is four 0 bits, then the 10-bit straight-binary sample MSB first, then two 0 bits. Word bit 15 is valid at the first rising edge and word bit 0 at the sixteenth.
- R7: `trackPhase` is 1 after falling edges 1 to 3 of a conversion and 0 from falling edge 4 on. The sample is taken from the selected port at falling edge 4. A port change before that edge appears in the word. A change after it does not.
- R8: After rising edge 16 of a conversion, the next falling edge inside the same frame starts a new conversion at edge 1.
- R9: If `sclk` is low when `csN` falls, the fall of `csN` counts as falling edge 1. If `sclk` is high, the first real falling edge counts as edge 1.
- R10: `powerDown` is 1 while `csN` is high. It is also 1 from falling edge 16 of a conversion until falling edge 1 of the next, and 0 after falling edges 1 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select; frames the transfer |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial control data from the host |
| chanData | input | 40 | Four 10-bit samples; port k at bits [10k+9:10k] |
| sdoBit | output | 1 | Serial result bit |
| sdoOe | output | 1 | Output enable for the serial result pad |
| powerDown | output | 1 | Power-down window flag |
| trackPhase | output | 1 | Tracking window flag |

## Verification
The checks assume that every level of `sclk` and `csN` lasts longer than the synchronizer depth plus two system clocks. They also assume that `sdi` is steady around each rising serial edge and that a selected port does not change in the few system clocks around falling edge 4. The stimulus uses 40 ns serial half periods against a 5 ns system clock. It moves every pin at instants offset from the system clock edges and changes ports only at falling serial edges, so each edge is seen once and cleanly. The scenarios cover frames that start with the clock idle low and idle high, back-to-back conversions, control words with every ignored bit set, and port changes on each side of the hold edge.

// File: rtl/adcs_pkg.sv
`timescale 1ns/1ps
package adcs_pkg;

  // Strobes from the control path to the datapath, each valid for one clk.
  typedef struct packed {
    logic fallEv;      // a counted falling serial edge
    logic holdLoad;    // hold instant: latch the selected sample
    logic shiftOut;    // falling edge that emits a sample/trailer bit
    logic ctrlShiftEn; // rising edge inside the control-word window
    logic ctrlDone;    // last control bit arrives now
    logic convEnd;     // final rising edge of a conversion
    logic frameIdle;   // select is high
  } adcsStrobe_t;

endpackage

// File: rtl/adcs_sync.sv
`timescale 1ns/1ps
module adcs_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/adcs_ctrl.sv
`timescale 1ns/1ps
module adcs_ctrl
  import adcs_pkg::*;
#(
  parameter int CONV_LEN    = 16,
  parameter int CTRL_LEN    = 8,
  parameter int HOLD_EDGE   = 4,
  parameter int LEAD_ZEROS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output adcsStrobe_t strobes,
  output logic        serialIn,
  output logic        powerDown,
  output logic        trackPhase
);

  localparam int CNT_W = $clog2(CONV_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(CONV_LEN);
  localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(CONV_LEN - 1);
  localparam logic [CNT_W-1:0] HOLD_AT   = CNT_W'(HOLD_EDGE - 1);
  localparam logic [CNT_W-1:0] LEAD_CNT  = CNT_W'(LEAD_ZEROS);
  localparam logic [CNT_W-1:0] CTRL_CNT  = CNT_W'(CTRL_LEN);
  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_LEN - 1);

  logic [2:0] pinsSync;
  logic csS, sclkS, csD, sclkD;
  logic fallEv, riseEv;
  logic [CNT_W-1:0] fallCnt, riseCnt;

  adcs_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({csN, sclk, sdi}),
    .syncOut(pinsSync)
  );

  assign csS      = pinsSync[2];
  assign sclkS    = pinsSync[1];
  assign serialIn = pinsSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD   <= 1'b1;
      sclkD <= 1'b0;
    end else begin
      csD   <= csS;
      sclkD <= sclkS;
    end
  end

  // A fall is counted when the clock is low inside a frame and either the
  // clock just dropped or the frame just opened with the clock already low.
  assign fallEv = !csS && !sclkS && (csD || sclkD) && (fallCnt != LAST_FALL);
  // A rise is counted only inside an already open frame and after its fall.
  assign riseEv = !csS && !csD && sclkS && !sclkD && (riseCnt < fallCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallCnt <= '0;
      riseCnt <= '0;
    end else if (csS) begin
      fallCnt <= '0;
      riseCnt <= '0;
    end else if (riseEv && (riseCnt == LAST_RISE)) begin
      fallCnt <= '0;
      riseCnt <= '0;
    end else begin
      if (fallEv) fallCnt <= fallCnt + 1'b1;
      if (riseEv) riseCnt <= riseCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.fallEv      = fallEv;
    strobes.holdLoad    = fallEv && (fallCnt == HOLD_AT);
    strobes.shiftOut    = fallEv && (fallCnt >= LEAD_CNT);
    strobes.ctrlShiftEn = riseEv && (riseCnt < CTRL_CNT);
    strobes.ctrlDone    = riseEv && (riseCnt == CTRL_LAST);
    strobes.convEnd     = riseEv && (riseCnt == LAST_RISE);
    strobes.frameIdle   = csS;
  end

  assign trackPhase = (fallCnt != '0) && (fallCnt <= HOLD_AT);
  assign powerDown  = csS || (fallCnt == '0) || (fallCnt == LAST_FALL);

endmodule

// File: rtl/adcs_datapath.sv
`timescale 1ns/1ps
module adcs_datapath
  import adcs_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int NUM_CH      = 4,
  parameter int ADDR_LSB    = 3,
  parameter int TRAIL_ZEROS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  adcsStrobe_t              strobes,
  input  logic                     serialIn,
  input  logic [NUM_CH*DATA_W-1:0] chanData,
  output logic                     sdoBit,
  output logic                     sdoOe
);

  localparam int ADDR_W  = $clog2(NUM_CH);
  localparam int SHIFT_W = DATA_W + TRAIL_ZEROS;
  // Only the control bits up to the address field are kept; older bits
  // (ignored fields) fall off the top of the window.
  localparam int KEEP_W  = ADDR_LSB + ADDR_W - 1;

  logic [DATA_W-1:0]  chanArr [NUM_CH];
  logic [DATA_W-1:0]  selSample;
  logic [SHIFT_W-1:0] outShift;
  logic [KEEP_W-1:0]  ctrlWin;
  logic [ADDR_W-1:0]  nextChan, curChan;
  logic               sdoReg, oeReg;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chanArr[g] = chanData[g*DATA_W +: DATA_W];
  end

  assign selSample = chanArr[curChan];

  // Address pipeline: captured mid-conversion, applied at conversion end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWin  <= '0;
      nextChan <= '0;
      curChan  <= '0;
    end else begin
      if (strobes.ctrlShiftEn) ctrlWin <= {ctrlWin[KEEP_W-2:0], serialIn};
      if (strobes.ctrlDone)    nextChan <= ctrlWin[KEEP_W-1 -: ADDR_W];
      if (strobes.convEnd)     curChan <= nextChan;
    end
  end

  // Sample hold and serial result shifter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      sdoReg   <= 1'b0;
    end else begin
      if (strobes.holdLoad)      outShift <= {selSample, {TRAIL_ZEROS{1'b0}}};
      else if (strobes.shiftOut) outShift <= outShift << 1;
      if (strobes.fallEv)        sdoReg <= strobes.shiftOut ? outShift[SHIFT_W-1] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeReg <= 1'b0;
    else       oeReg <= !strobes.frameIdle;
  end

  assign sdoBit = sdoReg;
  assign sdoOe  = oeReg;

endmodule

// File: rtl/serial_adc_port.sv
`timescale 1ns/1ps
module serial_adc_port
  import adcs_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int NUM_CH      = 4,
  parameter int CONV_LEN    = 16,
  parameter int CTRL_LEN    = 8,
  parameter int ADDR_LSB    = 3,
  parameter int HOLD_EDGE   = 4,
  parameter int LEAD_ZEROS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sclk,
  input  logic                     sdi,
  input  logic [NUM_CH*DATA_W-1:0] chanData,
  output logic                     sdoBit,
  output logic                     sdoOe,
  output logic                     powerDown,
  output logic                     trackPhase
);

  localparam int TRAIL_ZEROS = CONV_LEN - LEAD_ZEROS - DATA_W;

  adcsStrobe_t strobes;
  logic        serialIn;

  adcs_ctrl #(
    .CONV_LEN   (CONV_LEN),
    .CTRL_LEN   (CTRL_LEN),
    .HOLD_EDGE  (HOLD_EDGE),
    .LEAD_ZEROS (LEAD_ZEROS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sclk      (sclk),
    .sdi       (sdi),
    .strobes   (strobes),
    .serialIn  (serialIn),
    .powerDown (powerDown),
    .trackPhase(trackPhase)
  );

  adcs_datapath #(
    .DATA_W     (DATA_W),
    .NUM_CH     (NUM_CH),
    .ADDR_LSB   (ADDR_LSB),
    .TRAIL_ZEROS(TRAIL_ZEROS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .serialIn(serialIn),
    .chanData(chanData),
    .sdoBit  (sdoBit),
    .sdoOe   (sdoOe)
  );

endmodule

// File: rtl/serial_adc_port_chk.sv
`timescale 1ns/1ps
module serial_adc_port_chk
  import adcs_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input adcsStrobe_t strobes,
  input logic        sdoBit,
  input logic        sdoOe,
  input logic        powerDown
);

  // R1
  oe_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameIdle |=> !sdoOe);

  // R2
  sdo_fall_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fallEv |=> $stable(sdoBit));

  // R6
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fallEv && !strobes.shiftOut) |=> !sdoBit);

  // R7
  hold_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.holdLoad, strobes.shiftOut}));

  // R7
  hold_in_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdLoad |-> (strobes.fallEv && !powerDown));

  // R10
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameIdle |=> powerDown);

  // R8
  conv_end_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.convEnd |=> powerDown);

endmodule

bind serial_adc_port serial_adc_port_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strobes  (strobes),
  .sdoBit   (sdoBit),
  .sdoOe    (sdoOe),
  .powerDown(powerDown)
);

// File: tb/serial_adc_port_tb.sv
`timescale 1ns/1ps
module serial_adc_port_tb;

  localparam int HALF = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic [39:0] chanData = '0;
  logic        sdoBit, sdoOe, powerDown, trackPhase;

  int checks = 0;
  int errors = 0;

  serial_adc_port u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sclk      (sclk),
    .sdi       (sdi),
    .chanData  (chanData),
    .sdoBit    (sdoBit),
    .sdoOe     (sdoOe),
    .powerDown (powerDown),
    .trackPhase(trackPhase)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [9:0] v);
    return {4'b0000, v, 2'b00};
  endfunction

  function automatic logic [9:0] port(input int k);
    return chanData[k*10 +: 10];
  endfunction

  // One 16-clock conversion. skipFall: the select fall already was edge 1.
  task automatic runConv(input logic [7:0] ctrl, input bit skipFall,
                         input int chgAt, input int chgCh, input logic [9:0] chgVal,
                         output logic [15:0] word, output logic [15:0] trk,
                         output logic [15:0] pd, output bit oeAll);
    oeAll = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      if (!(skipFall && i == 1)) sclk = 1'b0;
      sdi = (i <= 8) ? ctrl[8-i] : 1'b0;
      if (i == chgAt) chanData[chgCh*10 +: 10] = chgVal;
      #(HALF);
      word[16-i] = sdoBit;
      trk[i-1]   = trackPhase;
      pd[i-1]    = powerDown;
      oeAll      = oeAll & sdoOe;
      sclk = 1'b1;
      #(HALF);
    end
  endtask

  task automatic openFrame(input bit idleLow);
    sclk = idleLow ? 1'b0 : 1'b1;
    #(HALF);
    csN = 1'b0;
    if (!idleLow) #(HALF);
  endtask

  task automatic closeFrame(input string tag);
    csN = 1'b1;
    #(HALF);
    check(sdoOe == 1'b0, {"R1 oe off after frame ", tag}, sdoOe, 0);
    check(powerDown == 1'b1, {"R10 pd with select high ", tag}, powerDown, 1);
  endtask

  task automatic t_reset;
    check(sdoOe == 1'b0, "R1 reset oe", sdoOe, 0);
    check(powerDown == 1'b1, "R10 reset pd", powerDown, 1);
    check(trackPhase == 1'b0, "R7 reset track", trackPhase, 0);
  endtask

  // Idle-low start, first conversion after reset uses port 0.
  task automatic t_firstConv;
    logic [15:0] w, trk, pd; bit oe;
    openFrame(1'b1);
    runConv(8'h10, 1'b1, 0, 0, '0, w, trk, pd, oe);
    check(w == expWord(port(0)), "R5 R6 R9 first word port0", w, expWord(port(0)));
    check(oe, "R1 oe during frame", oe, 1);
    check(trk == 16'h0007, "R7 track window", trk, 16'h0007);
    check(pd == 16'h8000, "R10 pd within conversion", pd, 16'h8000);
    closeFrame("first");
  endtask

  // Idle-high start, three back-to-back conversions, pipelined address.
  task automatic t_pipeline;
    logic [15:0] w, trk, pd; bit oe;
    logic [7:0]  ctrls [3] = '{8'h08, 8'h18, 8'h00};
    int          expCh [3] = '{2, 1, 3};
    openFrame(1'b0);
    for (int c = 0; c < 3; c++) begin
      runConv(ctrls[c], 1'b0, 0, 0, '0, w, trk, pd, oe);
      check(w == expWord(port(expCh[c])), "R4 R8 R9 pipelined word", w, expWord(port(expCh[c])));
      check(trk == 16'h0007, "R8 track restarts each conversion", trk, 16'h0007);
      check(powerDown == 1'b1, "R10 pd between conversions", powerDown, 1);
    end
    closeFrame("pipeline");
  endtask

  // Ignored control bits set; address persists across frames.
  task automatic t_dontCare;
    logic [15:0] w, trk, pd; bit oe;
    logic [7:0]  ctrls [3] = '{8'hEF, 8'hF7, 8'h00};
    int          expCh [3] = '{0, 1, 2};
    openFrame(1'b1);
    for (int c = 0; c < 3; c++) begin
      runConv(ctrls[c], c == 0, 0, 0, '0, w, trk, pd, oe);
      check(w == expWord(port(expCh[c])), "R3 R4 ignored bits", w, expWord(port(expCh[c])));
    end
    closeFrame("dontcare");
  endtask

  // Port changes before and after the hold edge.
  task automatic t_holdLatch;
    logic [15:0] w, trk, pd; bit oe;
    openFrame(1'b0);
    runConv(8'h00, 1'b0, 2, 0, 10'h155, w, trk, pd, oe);
    check(w == expWord(10'h155), "R7 change before hold seen", w, expWord(10'h155));
    runConv(8'h00, 1'b0, 5, 0, 10'h0AA, w, trk, pd, oe);
    check(w == expWord(10'h155), "R7 change after hold ignored", w, expWord(10'h155));
    runConv(8'h00, 1'b0, 0, 0, '0, w, trk, pd, oe);
    check(w == expWord(10'h0AA), "R2 R7 later conversion sees new value", w, expWord(10'h0AA));
    closeFrame("hold");
  endtask

  initial begin
    chanData = {10'h3FF, 10'h001, 10'h200, 10'h2C5};
    #50;
    t_reset;
    rstN = 1'b1;
    #(HALF);
    t_reset;
    t_firstConv;
    t_pipeline;
    t_dontCare;
    t_holdLatch;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule